// File: doc/BRIEF.md
# Page-Mode Nonvolatile Write Sequencer

This block is a clocked model of the write side of a byte-wide nonvolatile memory. An external agent loads bytes with two active-low strobes, chip enable and write enable. Both are sampled on the system clock. A load is active while both are low. The byte offset and the page number are taken when the load becomes active. The data byte is taken when the load ends. Up to one page of bytes collects in a page buffer, and every byte of one page operation must name the same page.

When no accepted load has happened for a programmable window, the block starts an internal programming cycle on its own. It holds busy for a fixed number of cycles. It then writes into the behavioural memory array only the buffer slots that were loaded, and pulses done. An active-low inhibit input blocks loading and reading. If inhibit drops during programming, the cycle is cancelled and the array is left untouched. All time limits are parameters counted in clock cycles.

Top module: `page_write_seq`

## Requirements
- R1: After reset, busy, done and load_err are low, and every array byte reads back as the FILL value (default 8'hFF).
- R2: A load becomes active on the first clock where ce_n and we_n are both sampled low. In that cycle, addr[PAGE_W-1:0] selects the buffer slot and addr[ADDR_W-1:PAGE_W] selects the page. The data byte is din as sampled on the first clock where either strobe is high again. Later changes to addr during the load have no effect.
- R3: busy rises exactly WIN clock edges after the edge that took the last accepted data byte. It stays high for exactly PROG_CYC cycles. done is a one-cycle pulse that appears in the cycle where busy falls.
- R4: A commit writes only the slots loaded during this page operation, and the other bytes of the page keep their contents. If one slot is loaded twice, the later byte is written.
- R5: A load during a page operation whose page field differs from the page of the first load raises load_err for one cycle. The load is ignored and leaves the buffer unchanged.
- R6: A load that becomes active more than LOAD_MAX cycles after the previous accepted load became active raises load_err and is ignored. A load exactly LOAD_MAX cycles later is accepted.
- R7: Strobes while busy is high are ignored. They raise no load_err, change no array byte and start no further programming cycle.
- R8: While res_n is low, strobes are ignored and rd_data reads 0. A page load still collecting when res_n falls is discarded.
- R9: If res_n is low during programming, busy drops at the next edge, no done pulse is given, and the array keeps its previous contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_n | input | 1 | Active-low inhibit: blocks loads and reads, cancels programming |
| ce_n | input | 1 | Active-low chip enable strobe |
| we_n | input | 1 | Active-low write enable strobe |
| addr | input | ADDR_W | Byte address: page field on top, slot field below |
| din | input | DATA_W | Data byte to load |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | DATA_W | Array byte at rd_addr, 0 while inhibited |
| busy | output | 1 | High during the internal programming cycle |
| done | output | 1 | One-cycle pulse when programming completes |
| load_err | output | 1 | One-cycle pulse when a load is rejected |

## Verification
The bench uses a configuration with 8-byte pages and 4 pages, and reads all 32 array bytes back after every operation against an arithmetic model. Page loads are tried as a single byte, as a full page in reverse slot order, and as a sparse reload with one slot written twice. Together these tell a whole-page commit apart from a slot-masked commit, and first-write-wins apart from last-write-wins. Gap tests place a load exactly at and one cycle past the load limit, and a foreign-page load sits between good ones. Other tests move addr and din in the middle of a strobe and pulse inhibit before and during programming, which separates capture at the strobe start from capture at the strobe end and separates a cancelled commit from a completed one.

// File: rtl/pws_pkg.sv
package pws_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOAD = 2'd1,
      ST_PROG = 2'd2
   } pws_state_e;
endpackage

// File: rtl/pws_strobe.sv
module pws_strobe (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_n,
   input  logic we_n,
   output logic act,
   output logic act_q,
   output logic start,
   output logic stop
);
   // a load is active only while both strobes are low
   assign act = ~ce_n & ~we_n;

   always_ff @(posedge clk) begin
      if (!rst_n) act_q <= 1'b0;
      else        act_q <= act;
   end

   assign start = act & ~act_q;   // last strobe went low
   assign stop  = ~act & act_q;   // first strobe went high
endmodule

// File: rtl/pws_sat_counter.sv
module pws_sat_counter #(
   parameter int MAX = 15,
   parameter int W   = $clog2(MAX + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   output logic [W-1:0] cnt
);
   if (MAX < 1) begin : g_bad_max
      $error("pws_sat_counter: MAX must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                        cnt <= '0;
      else if (clr)                      cnt <= '0;
      else if (en && cnt != W'(MAX))     cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/pws_page_buffer.sv
module pws_page_buffer #(
   parameter int PAGE_W = 7,
   parameter int DATA_W = 8
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                clear,
   input  logic                                wr_en,
   input  logic [PAGE_W-1:0]                   wr_off,
   input  logic [DATA_W-1:0]                   wr_data,
   output logic [(1<<PAGE_W)-1:0][DATA_W-1:0]  data_o,
   output logic [(1<<PAGE_W)-1:0]              valid_o
);
   localparam int SLOTS = 1 << PAGE_W;

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      logic hit;
      assign hit = wr_en && (wr_off == PAGE_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid_o[g] <= 1'b0;
            data_o[g]  <= '0;
         end else if (clear) begin
            valid_o[g] <= 1'b0;
         end else if (hit) begin
            valid_o[g] <= 1'b1;
            data_o[g]  <= wr_data;
         end
      end
   end
endmodule

// File: rtl/page_write_seq.sv
module page_write_seq
   import pws_pkg::*;
#(
   parameter int ADDR_W   = 9,
   parameter int PAGE_W   = 7,
   parameter int DATA_W   = 8,
   parameter int LOAD_MAX = 3000,
   parameter int WIN      = 10000,
   parameter int PROG_CYC = 1500000,
   parameter int FILL     = 255
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              res_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              busy,
   output logic              done,
   output logic              load_err
);
   localparam int SLOTS = 1 << PAGE_W;
   localparam int PG_W  = ADDR_W - PAGE_W;
   localparam int DEPTH = 1 << ADDR_W;
   localparam int GAP_W = $clog2(LOAD_MAX + 1);
   localparam int WIN_W = $clog2(WIN + 1);
   localparam int PRG_W = $clog2(PROG_CYC + 1);
   localparam logic [GAP_W-1:0] GAP_LIM  = GAP_W'(LOAD_MAX);
   localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN - 1);
   localparam logic [PRG_W-1:0] PRG_LAST = PRG_W'(PROG_CYC - 1);
   localparam logic [DATA_W-1:0] FILL_V  = DATA_W'(FILL);

   // elaboration-time parameter checks
   if (PAGE_W < 1 || PAGE_W >= ADDR_W) begin : g_bad_page
      $error("page_write_seq: PAGE_W must be in 1..ADDR_W-1");
   end
   if (DEPTH > 4096) begin : g_bad_depth
      $error("page_write_seq: behavioural array limited to 4096 bytes");
   end
   if (LOAD_MAX < 1 || WIN <= LOAD_MAX) begin : g_bad_win
      $error("page_write_seq: need 1 <= LOAD_MAX < WIN");
   end
   if (PROG_CYC < 2) begin : g_bad_prog
      $error("page_write_seq: PROG_CYC must be at least 2");
   end

   pws_state_e           state;
   logic                 act, act_q, start, stop;
   logic                 pend;
   logic [PG_W-1:0]      page_q;
   logic [PAGE_W-1:0]    off_q;
   logic [GAP_W-1:0]     gap_cnt;
   logic [WIN_W-1:0]     win_cnt;
   logic [PRG_W-1:0]     prg_cnt;
   logic                 accept, reject, win_done, prg_last, commit, wr_en, buf_clr;
   logic [SLOTS-1:0][DATA_W-1:0] buf_data;
   logic [SLOTS-1:0]     buf_valid;
   logic [DATA_W-1:0]    mem [DEPTH];

   wire [PG_W-1:0]   in_page = addr[ADDR_W-1:PAGE_W];
   wire [PAGE_W-1:0] in_off  = addr[PAGE_W-1:0];

   pws_strobe u_strobe (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
      .act(act), .act_q(act_q), .start(start), .stop(stop)
   );

   // ---- load acceptance ----
   always_comb begin
      accept = 1'b0;
      if (start && res_n) begin
         if (state == ST_IDLE)
            accept = 1'b1;
         else if (state == ST_LOAD)
            accept = (in_page == page_q) && (gap_cnt < GAP_LIM);
      end
   end

   assign reject   = start && res_n && (state == ST_LOAD) && !accept;
   assign wr_en    = (state == ST_LOAD) && stop && pend && res_n;
   assign win_done = (state == ST_LOAD) && !pend && (win_cnt >= WIN_LAST) && !accept;
   assign prg_last = (state == ST_PROG) && (prg_cnt == PRG_LAST);
   assign commit   = prg_last && res_n;
   assign buf_clr  = commit || !res_n;

   // gap since last accepted start, window since last data, programming length
   pws_sat_counter #(.MAX(LOAD_MAX), .W(GAP_W)) u_gap (
      .clk(clk), .rst_n(rst_n), .clr(accept), .en(1'b1), .cnt(gap_cnt)
   );
   pws_sat_counter #(.MAX(WIN), .W(WIN_W)) u_win (
      .clk(clk), .rst_n(rst_n), .clr((state != ST_LOAD) || pend), .en(1'b1), .cnt(win_cnt)
   );
   pws_sat_counter #(.MAX(PROG_CYC), .W(PRG_W)) u_prg (
      .clk(clk), .rst_n(rst_n), .clr(state != ST_PROG), .en(1'b1), .cnt(prg_cnt)
   );

   pws_page_buffer #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .clear(buf_clr), .wr_en(wr_en),
      .wr_off(off_q), .wr_data(din), .data_o(buf_data), .valid_o(buf_valid)
   );

   // ---- sequencing ----
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         pend     <= 1'b0;
         page_q   <= '0;
         off_q    <= '0;
         done     <= 1'b0;
         load_err <= 1'b0;
      end else begin
         done     <= 1'b0;
         load_err <= reject;
         if (!res_n) begin
            state <= ST_IDLE;
            pend  <= 1'b0;
         end else begin
            if (accept) begin
               off_q <= in_off;
               pend  <= 1'b1;
               if (state == ST_IDLE) begin
                  page_q <= in_page;
                  state  <= ST_LOAD;
               end
            end else if (wr_en) begin
               pend <= 1'b0;
            end
            if (win_done) state <= ST_PROG;
            if (commit) begin
               done  <= 1'b1;
               state <= ST_IDLE;
            end
         end
      end
   end

   // ---- behavioural array, masked page commit ----
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= FILL_V;
      end else if (commit) begin
         for (int i = 0; i < SLOTS; i++)
            if (buf_valid[i]) mem[{page_q, PAGE_W'(i)}] <= buf_data[i];
      end
   end

   assign rd_data = res_n ? mem[rd_addr] : '0;
   assign busy    = (state == ST_PROG);
endmodule

// File: rtl/page_write_seq_chk.sv
module page_write_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic res_n,
   input logic busy,
   input logic done,
   input logic load_err
);
   // R3: done appears only as busy falls
   a_r3_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(busy) && !busy));

   // R3, R9: busy ends with done unless inhibit cancelled the cycle
   a_r3_fall_has_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (done || !$past(res_n)));

   // R3: programming lasts more than one cycle while not inhibited
   a_r3_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy) && res_n) |=> busy);

   // R9: no completion while inhibited
   a_r9_no_done_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
      !res_n |=> !done);

   // R8: inhibit keeps the block out of programming
   a_r8_inhibit_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !res_n |=> !busy);

   // R7: no load rejection reported while programming
   a_r7_no_err_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !load_err);

   // R5, R6: rejection is a single-cycle pulse
   a_r5_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      load_err |=> !load_err);
endmodule

bind page_write_seq page_write_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .res_n(res_n),
   .busy(busy), .done(done), .load_err(load_err)
);

// File: tb/page_write_seq_test.sv
module page_write_seq_test;
   localparam int AW = 5, PW = 3, DW = 8;
   localparam int LMAX = 8, WIN = 20, PROG = 12;
   localparam int NB = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0, res_n = 1'b1, ce_n = 1'b1, we_n = 1'b1;
   logic [AW-1:0] addr = '0, rd_addr = '0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] rd_data;
   logic busy, done, load_err;

   int errs = 0, checks = 0;
   logic [DW-1:0] refm [NB];
   logic [DW-1:0] pb [1<<PW];
   logic [(1<<PW)-1:0] pv = '0;
   logic [AW-PW-1:0] ppg = '0;
   logic errseen;

   always #2 clk = ~clk;

   page_write_seq #(.ADDR_W(AW), .PAGE_W(PW), .DATA_W(DW), .LOAD_MAX(LMAX),
                    .WIN(WIN), .PROG_CYC(PROG), .FILL(255)) uut (
      .clk(clk), .rst_n(rst_n), .res_n(res_n), .ce_n(ce_n), .we_n(we_n),
      .addr(addr), .din(din), .rd_addr(rd_addr), .rd_data(rd_data),
      .busy(busy), .done(done), .load_err(load_err)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // model helpers
   task automatic note(input logic [AW-1:0] a, input logic [DW-1:0] d);
      pb[a[PW-1:0]] = d;
      pv[a[PW-1:0]] = 1'b1;
      ppg = a[AW-1:PW];
   endtask
   task automatic commit_ref();
      for (int i = 0; i < (1<<PW); i++)
         if (pv[i]) refm[{ppg, PW'(i)}] = pb[i];
      pv = '0;
   endtask

   task automatic load(input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input int idle, output logic e);
      @(negedge clk);
      addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
      @(negedge clk);
      e = load_err;
      @(negedge clk);
      we_n = 1'b1; ce_n = 1'b1;
      repeat (idle) @(negedge clk);
   endtask

   task automatic wait_prog(input string tag, input int exp_win);
      int n = 0, m = 0;
      while (!busy && n < 400) begin @(negedge clk); n++; end
      chk({tag, " window"}, n, exp_win);
      while (busy && m < 400) begin m++; @(negedge clk); end
      chk({tag, " busy length"}, m, PROG);
      chk({tag, " done pulse"}, done, 1);
      @(negedge clk);
      chk({tag, " done one cycle"}, done, 0);
   endtask

   task automatic sweep(input string tag);
      for (int a = 0; a < NB; a++) begin
         @(negedge clk);
         rd_addr = AW'(a);
         #1;
         chk(tag, rd_data, refm[a]);
      end
   endtask

   task automatic quiet(input string tag, input int cyc);
      int seen = 0;
      repeat (cyc) begin @(negedge clk); if (busy) seen++; end
      chk(tag, seen, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < NB; i++) refm[i] = 8'hFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 busy", busy, 0);
      chk("R1 done", done, 0);
      chk("R1 load_err", load_err, 0);
      sweep("R1 fill");

      // R2/R3 single byte, page 1 slot 3
      load(5'd11, 8'hA5, 0, errseen); note(5'd11, 8'hA5);
      chk("R2 accept", errseen, 0);
      wait_prog("R3 single", WIN + 1); commit_ref();
      sweep("R2 single byte");

      // R2/R4 full page 2 in reverse slot order
      for (int s = 7; s >= 0; s--) begin
         load(AW'(16 + s), DW'(8'h30 + s * 7), 0, errseen);
         note(AW'(16 + s), DW'(8'h30 + s * 7));
         chk("R2 full page accept", errseen, 0);
      end
      wait_prog("R3 full", WIN + 1); commit_ref();
      sweep("R4 full page");

      // R4 sparse reload, slot 5 twice: later byte wins
      load(5'd21, 8'h11, 0, errseen); note(5'd21, 8'h11);
      load(5'd16, 8'h22, 0, errseen); note(5'd16, 8'h22);
      load(5'd21, 8'h33, 0, errseen); note(5'd21, 8'h33);
      wait_prog("R4 sparse", WIN + 1); commit_ref();
      sweep("R4 masked commit");

      // R5 foreign page load rejected
      load(5'd25, 8'h44, 0, errseen); note(5'd25, 8'h44);
      load(5'd1, 8'h55, 0, errseen);
      chk("R5 foreign page err", errseen, 1);
      load(5'd26, 8'h66, 0, errseen); note(5'd26, 8'h66);
      chk("R5 later load ok", errseen, 0);
      wait_prog("R5", WIN + 1); commit_ref();
      sweep("R5 buffer intact");

      // R6 gap limit: exactly LMAX accepted, LMAX+1 rejected
      load(5'd8, 8'h77, LMAX - 3, errseen); note(5'd8, 8'h77);
      load(5'd9, 8'h88, LMAX - 2, errseen); note(5'd9, 8'h88);
      chk("R6 gap at limit accepted", errseen, 0);
      load(5'd10, 8'h99, 0, errseen);
      chk("R6 gap past limit rejected", errseen, 1);
      wait_prog("R6", WIN - LMAX); commit_ref();
      sweep("R6 late byte dropped");

      // R7 strobes while busy ignored
      load(5'd4, 8'h12, 0, errseen); note(5'd4, 8'h12);
      begin
         int n = 0;
         while (!busy && n < 400) begin @(negedge clk); n++; end
         chk("R7 window", n, WIN + 1);
      end
      load(5'd5, 8'h34, 0, errseen);
      chk("R7 no err while busy", errseen, 0);
      while (busy) @(negedge clk);
      chk("R7 done", done, 1);
      commit_ref();
      quiet("R7 no second cycle", WIN + 5);
      sweep("R7 busy strobe ignored");

      // R8 inhibit blocks loads and reads
      res_n = 1'b0;
      load(5'd6, 8'h56, 0, errseen);
      rd_addr = 5'd11; #1;
      chk("R8 read blocked", rd_data, 0);
      quiet("R8 no programming", WIN + 5);
      res_n = 1'b1;
      sweep("R8 array unchanged");
      // R8 pending load discarded by inhibit pulse
      load(5'd7, 8'h78, 2, errseen);
      res_n = 1'b0;
      repeat (2) @(negedge clk);
      res_n = 1'b1;
      quiet("R8 pending discarded", WIN + 5);
      sweep("R8 discarded slot");

      // R9 inhibit during programming cancels
      load(5'd25, 8'h9A, 0, errseen);
      while (!busy) @(negedge clk);
      repeat (3) @(negedge clk);
      res_n = 1'b0;
      @(negedge clk);
      chk("R9 busy drops", busy, 0);
      chk("R9 no done", done, 0);
      begin
         int d = 0;
         repeat (PROG + 2) begin @(negedge clk); if (done) d++; end
         chk("R9 no later done", d, 0);
      end
      res_n = 1'b1;
      sweep("R9 array kept");

      // R2 capture points: slot at start, data at end
      @(negedge clk);
      addr = 5'd12; din = 8'h00; ce_n = 1'b0;
      @(negedge clk);
      we_n = 1'b0;
      @(negedge clk);
      addr = 5'd14; din = 8'hBE;
      @(negedge clk);
      we_n = 1'b1;
      note(5'd12, 8'hBE);
      @(negedge clk);
      ce_n = 1'b1;
      wait_prog("R2 capture", WIN);
      commit_ref();
      sweep("R2 address at start, data at end");

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule